// File: doc/BRIEF.md
# Masked-address I2C target controller

This block is the target (slave) side of a 7-bit I2C bus. A fast system clock oversamples the SCL and SDA lines through synchronisers. It tracks bus activity and reports bus-busy and bus-free conditions to a host. It compares each address byte against a programmed address through a per-bit mask, and it can also answer the general call address. Bytes written by the bus controller arrive in an internal shift register and are moved to a host-visible buffer. Bytes the controller reads are loaded by the host through the same buffer location, and that write goes straight into the transmit shift register.

The host uses a four-location register port. Select 0 is the data buffer. Select 1 is the own address, or the compare mask when the mask-access control bit is set. Select 2 is control: bit 0 enables general call and bit 1 enables mask access. Select 3 is status, with these bits: 0 buffer full, 1 bus busy (start seen), 2 bus free (stop seen), 3 overflow, 4 interrupt, 5 current transfer is a read, 6 last address was the general call. SDA is driven open-drain: when `sda_oe` is 1 the pad pulls the line low.

The sequencer states are IDLE, ADDR, ACK, RX, TX, TXACK and SKIP. A start moves any state to ADDR, and a stop moves any state to IDLE. The eighth SCL rise in ADDR or RX moves to ACK. ACK, on its second SCL fall, moves to RX, TX or SKIP. The eighth rise in TX moves to TXACK. The rise in TXACK moves to TX when the controller ACKs and to SKIP when it NACKs.

Top module: `i2c_mask_slave`

## Requirements
- R1: After reset the status reads 0x00, the own address reads 0x00, the mask reads 0x7F, control reads 0x00, and `sda_oe` and `irq` are 0.
- R2: A start (SDA falls while SCL is high) sets status bit 1 and clears bit 2. A stop (SDA rises while SCL is high) sets bit 2, clears bit 1 and returns the sequencer to IDLE with SDA released.
- R3: The address byte is the 7-bit address followed by the R/W bit (1 = read), sent MSB first. The block ACKs it by pulling SDA low in the ninth clock when ((addr ^ own) & mask) == 0. A mask bit of 0 makes that address bit a don't-care.
- R4: On an address mismatch the block NACKs and ignores every later byte until the next start or stop. It does not ACK, and the buffer and the full flag are left unchanged.
- R5: The write address 0x00 is ACKed as a general call only when control bit 0 is 1. An accepted general call sets status bit 6.
- R6: After the eighth bit of a received data byte (MSB first), the byte moves to the buffer, status bit 0 and `irq` are set, and the byte is ACKed.
- R7: If a data byte completes while the buffer is full, status bit 3 is set, the buffer keeps its old value, the byte is NACKed and the rest of the transfer is ignored.
- R8: A host read of select 0 clears the full flag. Writing 1 to status bit 3 or bit 4 clears the overflow flag or the interrupt flag.
- R9: A host write to select 0 loads both the buffer and the transmit shift register. In a read transfer the block shifts that byte out MSB first, with each bit stable while SCL is high.
- R10: When the controller ACKs a transmitted byte, `irq` is set and the next byte comes from the shift register. On a NACK the block releases SDA and ignores the bus until a start or stop.
- R11: Select 1 reaches the mask only while control bit 1 is 1. Otherwise it reaches the own address.
- R12: `sda_oe` is 1 only in an ACK slot the block grants or while the block transmits a 0 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (side effects on select 0) |
| reg_sel | input | 2 | Host register select |
| reg_wdata | input | DATA_W | Host write data |
| reg_rdata | output | DATA_W | Host read data for the selected register |
| irq | output | 1 | Interrupt flag (status bit 4) |

## Verification
The bench builds the block with its defaults: DATA_W = 8, which gives a 7-bit address plus the R/W bit, and SYNC_STAGES = 2. These values bring the full 7-bit mask within reach. The bench checks both a mask that ignores the four low address bits and the all-compare mask. With a ten-cycle quarter SCL period, the three-cycle synchroniser and edge-detect latency stays well inside each phase. This lets the bench test exact ACK-slot and bit-stability timing, and lets a host write land between the controller's ACK and the next SCL fall.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } i2cs_state_e;

    localparam logic [1:0] SEL_BUF = 2'd0;
    localparam logic [1:0] SEL_ADR = 2'd1;
    localparam logic [1:0] SEL_CTL = 2'd2;
    localparam logic [1:0] SEL_STS = 2'd3;

    localparam int STS_FULL = 0;
    localparam int STS_S    = 1;
    localparam int STS_P    = 2;
    localparam int STS_OVF  = 3;
    localparam int STS_IRQ  = 4;
    localparam int STS_RW   = 5;
    localparam int STS_GC   = 6;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d_i,
    output logic [LINES-1:0] q_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic bus_s,
    output logic bus_p
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_s <= 1'b0;
            bus_p <= 1'b0;
        end else if (start_det) begin
            bus_s <= 1'b1;
            bus_p <= 1'b0;
        end else if (stop_det) begin
            bus_s <= 1'b0;
            bus_p <= 1'b1;
        end
    end

    // R2
    s_p_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_s && bus_p));
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic              rx_rw,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] cmp_mask,
    input  logic              gc_en,
    output logic              own_hit,
    output logic              gc_hit
);
    assign own_hit = (((rx_addr ^ own_addr) & cmp_mask) == '0);
    assign gc_hit  = gc_en && !rx_rw && (rx_addr == '0);
endmodule

// File: rtl/i2c_mask_slave.sv
module i2c_mask_slave
    import i2cs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int ADDR_W = DATA_W - 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    logic [1:0] sync_q;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, bus_s, bus_p;

    i2cs_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(sync_q));
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    i2cs_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .bus_s(bus_s), .bus_p(bus_p));

    i2cs_state_e state_q, state_d, nxt_q;
    logic [DATA_W-1:0] rx_sr, tx_sr, buf_q, byte_in, sts;
    logic [ADDR_W-1:0] own_q, mask_q;
    logic [CNT_W-1:0]  cnt_q;
    logic ack_q, phase_q, sda_oe_q;
    logic full_q, ovf_q, irq_q, rw_q, gc_q, gc_en_q, macc_q;
    logic own_hit, gc_hit, acked, last_bit, host_buf_wr, host_buf_rd;

    assign byte_in     = {rx_sr[DATA_W-2:0], sda_s};
    assign last_bit    = (cnt_q == CNT_W'(DATA_W - 1));
    assign host_buf_wr = reg_wr && (reg_sel == SEL_BUF);
    assign host_buf_rd = reg_rd && (reg_sel == SEL_BUF);

    i2cs_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .rx_addr(byte_in[DATA_W-1:1]), .rx_rw(byte_in[0]),
        .own_addr(own_q), .cmp_mask(mask_q), .gc_en(gc_en_q),
        .own_hit(own_hit), .gc_hit(gc_hit));
    assign acked = own_hit || gc_hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_IDLE;
            ST_ADDR:  if (scl_rise && last_bit) state_d = ST_ACK;
            ST_ACK:   if (scl_fall && phase_q)  state_d = nxt_q;
            ST_RX:    if (scl_rise && last_bit) state_d = ST_ACK;
            ST_TX:    if (scl_rise && last_bit) state_d = ST_TXACK;
            ST_TXACK: if (scl_rise)             state_d = sda_s ? ST_SKIP : ST_TX;
            ST_SKIP:  state_d = ST_SKIP;
        endcase
        if (start_det)     state_d = ST_ADDR;
        else if (stop_det) state_d = ST_IDLE;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0; tx_sr <= '0; buf_q <= '0;
            own_q <= '0; mask_q <= '1; cnt_q <= '0;
            nxt_q <= ST_IDLE;
            ack_q <= 1'b0; phase_q <= 1'b0; sda_oe_q <= 1'b0;
            full_q <= 1'b0; ovf_q <= 1'b0; irq_q <= 1'b0;
            rw_q <= 1'b0; gc_q <= 1'b0; gc_en_q <= 1'b0; macc_q <= 1'b0;
        end else begin
            // host side
            if (reg_wr) begin
                unique case (reg_sel)
                    SEL_BUF: begin
                        buf_q <= reg_wdata;
                        tx_sr <= reg_wdata;
                    end
                    SEL_ADR: begin
                        if (macc_q) mask_q <= reg_wdata[ADDR_W-1:0];
                        else        own_q  <= reg_wdata[ADDR_W-1:0];
                    end
                    SEL_CTL: begin
                        gc_en_q <= reg_wdata[0];
                        macc_q  <= reg_wdata[1];
                    end
                    SEL_STS: begin
                        if (reg_wdata[STS_OVF]) ovf_q <= 1'b0;
                        if (reg_wdata[STS_IRQ]) irq_q <= 1'b0;
                    end
                endcase
            end
            if (host_buf_rd) full_q <= 1'b0;

            // bus side (wins over host on the same cycle)
            if (start_det || stop_det) begin
                cnt_q    <= '0;
                phase_q  <= 1'b0;
                sda_oe_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR: if (scl_rise) begin
                        rx_sr <= byte_in;
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (last_bit) begin
                            rw_q    <= byte_in[0];
                            gc_q    <= gc_hit;
                            ack_q   <= acked;
                            phase_q <= 1'b0;
                            if (acked && byte_in[0]) begin
                                nxt_q <= ST_TX;
                                irq_q <= 1'b1;
                            end else if (acked) begin
                                nxt_q <= ST_RX;
                            end else begin
                                nxt_q <= ST_SKIP;
                            end
                        end
                    end
                    ST_RX: if (scl_rise) begin
                        rx_sr <= byte_in;
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (last_bit) begin
                            phase_q <= 1'b0;
                            if (full_q) begin
                                ovf_q <= 1'b1;
                                ack_q <= 1'b0;
                                nxt_q <= ST_SKIP;
                            end else begin
                                buf_q  <= byte_in;
                                full_q <= 1'b1;
                                irq_q  <= 1'b1;
                                ack_q  <= 1'b1;
                                nxt_q  <= ST_RX;
                            end
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!phase_q) begin
                            sda_oe_q <= ack_q;
                            phase_q  <= 1'b1;
                        end else begin
                            cnt_q    <= '0;
                            sda_oe_q <= (nxt_q == ST_TX) ? ~tx_sr[DATA_W-1] : 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) sda_oe_q <= ~tx_sr[DATA_W-1];
                        if (scl_rise) begin
                            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_TXACK: begin
                        if (scl_fall) sda_oe_q <= 1'b0;
                        if (scl_rise) begin
                            cnt_q <= '0;
                            if (!sda_s) irq_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        sts          = '0;
        sts[STS_FULL] = full_q;
        sts[STS_S]    = bus_s;
        sts[STS_P]    = bus_p;
        sts[STS_OVF]  = ovf_q;
        sts[STS_IRQ]  = irq_q;
        sts[STS_RW]   = rw_q;
        sts[STS_GC]   = gc_q;
        unique case (reg_sel)
            SEL_BUF: reg_rdata = buf_q;
            SEL_ADR: reg_rdata = {1'b0, (macc_q ? mask_q : own_q)};
            SEL_CTL: reg_rdata = {{(DATA_W-2){1'b0}}, macc_q, gc_en_q};
            SEL_STS: reg_rdata = sts;
        endcase
    end

    assign sda_oe = sda_oe_q;
    assign irq    = irq_q;

    // R7
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !host_buf_wr) |=> $stable(buf_q));
    // R4
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK && !ack_q) |-> !sda_oe_q);
    // R12
    oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_q |-> (state_q == ST_ACK || state_q == ST_TX || state_q == ST_TXACK));
    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_oe_q));
    // R6
    rx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX && scl_rise && last_bit && !full_q && !start_det && !stop_det)
        |=> (full_q && irq_q && buf_q == $past(byte_in)));
endmodule

// File: tb/tb_i2c_mask_slave.sv
module tb_i2c_mask_slave;
    import i2cs_pkg::*;

    localparam int DW = 8;
    localparam int Q  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe, irq;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_mask_slave #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct { string tag; int val; } exp_t;
    exp_t exp_q[$];
    int   obs_q[$];
    event obs_ev;

    task automatic check(string tag, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic push_exp(string tag, int v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        exp_q.push_back(e);
    endtask

    task automatic push_obs(int v);
        obs_q.push_back(v);
        ->obs_ev;
    endtask

    // scoreboard monitor
    initial begin
        int o;
        exp_t e;
        forever begin
            @(obs_ev);
            while (obs_q.size() > 0) begin
                o = obs_q.pop_front();
                if (exp_q.size() == 0) check("scoreboard underflow", o, -1);
                else begin
                    e = exp_q.pop_front();
                    check(e.tag, o, e.val);
                end
            end
        end
    end

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] sel, logic [DW-1:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] sel, output int d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = int'(reg_rdata);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; qw(); scl = 1'b1; qw(); s = sda_bus; qw(); scl = 1'b0; qw();
    endtask

    task automatic send_byte(string tag, logic [DW-1:0] d, int exp_ack);
        logic s;
        push_exp(tag, exp_ack);
        for (int i = DW - 1; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        push_obs(s ? 0 : 1);
    endtask

    task automatic recv_byte(string tag, int expv, bit m_ack, bit has_next,
                             logic [DW-1:0] nxt);
        logic s;
        logic [DW-1:0] v;
        push_exp(tag, expv);
        v = '0;
        for (int i = 0; i < DW; i++) begin
            clk_bit(1'b1, s);
            v = {v[DW-2:0], s};
        end
        sda_m = ~m_ack; qw();
        scl = 1'b1;
        if (has_next) reg_write(SEL_BUF, nxt);
        qw(); qw();
        scl = 1'b0; qw();
        sda_m = 1'b1;
        push_obs(int'(v));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        reg_read(SEL_STS, d); check("R1 status", d, 0);
        reg_read(SEL_ADR, d); check("R1 own address", d, 0);
        reg_read(SEL_CTL, d); check("R1 control", d, 0);
        reg_write(SEL_CTL, 8'h02);
        reg_read(SEL_ADR, d); check("R1 mask", d, 8'h7F);
        reg_write(SEL_CTL, 8'h00);
        check("R1 irq", int'(irq), 0);
        check("R1 sda_oe", int'(sda_oe), 0);

        reg_write(SEL_ADR, 8'h2A);

        // R3/R6 plain write
        bus_start();
        reg_read(SEL_STS, d); check("R2 start sets S clears P", d, 8'h02);
        send_byte("R3 exact address ack", {7'h2A, 1'b0}, 1);
        send_byte("R6 data byte ack", 8'hA5, 1);
        bus_stop();
        reg_read(SEL_STS, d); check("R2/R6 status after stop", d, 8'h15);
        check("R6 irq pin", int'(irq), 1);
        reg_read(SEL_BUF, d); check("R6 buffer MSB first", d, 8'hA5);
        reg_write(SEL_STS, 8'h18);
        reg_read(SEL_STS, d); check("R8 full and irq cleared", d, 8'h04);

        // R4 mismatch
        bus_start();
        send_byte("R4 mismatch nack", {7'h2B, 1'b0}, 0);
        send_byte("R4 ignored byte nack", 8'h11, 0);
        bus_stop();
        reg_read(SEL_STS, d); check("R4 no store after mismatch", d, 8'h04);
        reg_read(SEL_BUF, d); check("R4 buffer unchanged", d, 8'hA5);

        // R11 mask access
        reg_write(SEL_CTL, 8'h02);
        reg_write(SEL_ADR, 8'h70);
        reg_read(SEL_ADR, d); check("R11 mask via select 1", d, 8'h70);
        reg_write(SEL_CTL, 8'h00);
        reg_read(SEL_ADR, d); check("R11 address via select 1", d, 8'h2A);

        // R3 masked match, R7 overflow
        bus_start();
        send_byte("R3 masked address ack", {7'h25, 1'b0}, 1);
        send_byte("R6 first byte ack", 8'h3C, 1);
        send_byte("R7 overflow nack", 8'h77, 0);
        bus_stop();
        reg_read(SEL_STS, d); check("R7 overflow status", d, 8'h1D);
        reg_read(SEL_BUF, d); check("R7 buffer kept", d, 8'h3C);
        reg_write(SEL_STS, 8'h18);
        reg_read(SEL_STS, d); check("R8 overflow cleared", d, 8'h04);

        bus_start();
        send_byte("R3 masked bits differ nack", {7'h55, 1'b0}, 0);
        bus_stop();

        reg_write(SEL_CTL, 8'h02);
        reg_write(SEL_ADR, 8'h7F);
        reg_write(SEL_CTL, 8'h00);

        // R5 general call
        bus_start();
        send_byte("R5 general call disabled nack", 8'h00, 0);
        bus_stop();
        reg_write(SEL_CTL, 8'h01);
        bus_start();
        send_byte("R5 general call ack", 8'h00, 1);
        send_byte("R5 general call data ack", 8'h5A, 1);
        bus_stop();
        reg_read(SEL_STS, d); check("R5 general call status", d, 8'h55);
        reg_read(SEL_BUF, d); check("R5 general call data", d, 8'h5A);
        reg_write(SEL_STS, 8'h18);

        // R9/R10 read transfer
        reg_write(SEL_BUF, 8'hC3);
        reg_read(SEL_BUF, d); check("R9 buffer write readback", d, 8'hC3);
        bus_start();
        send_byte("R3 read address ack", {7'h2A, 1'b1}, 1);
        reg_write(SEL_STS, 8'h10);
        recv_byte("R9 first transmitted byte", 8'hC3, 1'b1, 1'b1, 8'h96);
        check("R10 irq after controller ack", int'(irq), 1);
        reg_write(SEL_STS, 8'h10);
        recv_byte("R9 second transmitted byte", 8'h96, 1'b0, 1'b0, 8'h00);
        recv_byte("R10/R12 released after nack", 8'hFF, 1'b0, 1'b0, 8'h00);
        check("R10 no irq after nack", int'(irq), 0);
        reg_read(SEL_STS, d); check("R5 gc flag cleared and read flagged", d, 8'h22);
        bus_stop();

        repeat (20) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule